// File: doc/BRIEF.md
# Codec Mixer Control Register Bank

This block holds the 16-bit control words of an audio codec's mixer and exposes them through a word-wide read/write port. Registers sit at even byte offsets. A synchronous reset loads a fixed set of power-on values. Each write passes through filtering rules before it reaches storage: identification words are protected, the power-down status nibble is kept, and the sample-rate words are gated by the variable-rate enables.

The stored words are also decoded into outputs that the rest of the chip uses directly. There are three outputs for each volume channel (mute, left attenuation and right attenuation). There are also the two record-source selects and the three active converter rates. Each converter rate has a one-cycle change strobe, so a clock generator downstream can retune when a rate moves.

Only word accesses take effect. Byte and dword accesses are dropped: they write nothing and return nothing.

Top module: `codec_mixer_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register reloads its default. Offset 0x02 loads 0x8000, 0x06 loads 0x8000, 0x0C loads 0x8008, 0x0E loads 0x8008, 0x10 loads 0x8808, 0x12 loads 0x8808, 0x16 loads 0x8808 and 0x18 loads 0x8808. Offset 0x1E loads 0x8000, 0x26 loads 0x000F, 0x28 loads 0x0809 and 0x2A loads 0x0009. Offsets 0x2C, 0x2E, 0x30, 0x32 and 0x34 load 0xBB80 (48000). Offset 0x7C loads 0x8384 and 0x7E loads 0x7600. Every other register loads zero.
- R2: A word read (`acc_size` = 1) raises `rd_valid` for one cycle on the following cycle, with the stored word on `rdata`. A read at an odd address, or at an address of 0xFF or more, returns 0xFFFF.
- R3: A byte access (`acc_size` = 0) or a dword access (`acc_size` = 2) neither changes any register nor raises `rd_valid`.
- R4: Writes to 0x7C, 0x7E and 0x28 are ignored.
- R5: A write to 0x26 stores bits 15:4 from the write data and keeps the stored bits 3:0.
- R6: Offsets 0x2C and 0x32 accept writes only while bit 0 of 0x2A (variable-rate enable) is set. Offset 0x34 accepts writes only while bit 3 of 0x2A (mic variable-rate enable) is set.
- R7: A write to 0x2A stores the data. If data bit 0 is clear, 0x2C and 0x32 are forced to 0xBB80 in the same cycle. If data bit 3 is clear, 0x34 is forced to 0xBB80.
- R8: Volume outputs are indexed 0 = 0x02, 1 = 0x10 and 2 = 0x18. Bit 15 of each word drives the mute output, bits 12:8 drive the 5-bit left attenuation and bits 4:0 drive the right attenuation.
- R9: A write to 0x1A keeps only bits 10:8 (left source) and bits 2:0 (right source), and the other bits read as zero. `rec_left` and `rec_right` show those fields.
- R10: `dac_rate`, `adc_rate` and `mic_rate` show 0x2C, 0x32 and 0x34. Each change strobe is high for exactly the one cycle in which its rate first shows a new value. Writing an unchanged value gives no strobe.
- R11: A word write to any other in-range even offset, such as 0x2E, stores the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, reloads defaults |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| addr | input | 9 | Byte offset |
| wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 16 | Read data |
| vol_mute | output | 3 | Mute per volume channel |
| vol_left | output | 15 | Left attenuation, 5 bits per channel |
| vol_right | output | 15 | Right attenuation, 5 bits per channel |
| rec_left | output | 3 | Left record source |
| rec_right | output | 3 | Right record source |
| dac_rate | output | 16 | Front DAC rate |
| adc_rate | output | 16 | Left/right ADC rate |
| mic_rate | output | 16 | Mic ADC rate |
| dac_rate_chg | output | 1 | DAC rate change strobe |
| adc_rate_chg | output | 1 | ADC rate change strobe |
| mic_rate_chg | output | 1 | Mic rate change strobe |

## Verification
The rate logic is tried under four enable patterns: both enables set, only the mic enable set, neither set, and a rewrite of an unchanged value. Together these separate the gating of each rate from the forcing on a control write, and separate real rate changes from plain writes. All-ones data written to the power-down and record-select words shows whether the preserved and masked bits are honoured. Odd addresses, out-of-range addresses and non-word sizes show that only aligned word accesses take effect. A reset in the middle of the run shows that defaults reload over modified state.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 9;
    localparam int SPACE_BYTES = 256;
    localparam int NREG        = SPACE_BYTES / 2;
    localparam int IDX_W       = $clog2(NREG);
    localparam int NVOL        = 3;
    localparam int ATT_W       = 5;
    localparam int SRC_W       = 3;
    localparam int NRATE       = 3;

    localparam logic [REG_W-1:0] RATE_48K = 16'hBB80;

    localparam int VRA_BIT = 0;
    localparam int VRM_BIT = 3;
    localparam int PD_KEEP = 4;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2
    } acc_size_e;

    // word indexes (byte offset / 2)
    localparam logic [IDX_W-1:0] IX_MASTER = 7'h01;
    localparam logic [IDX_W-1:0] IX_LINE   = 7'h08;
    localparam logic [IDX_W-1:0] IX_PCM    = 7'h0C;
    localparam logic [IDX_W-1:0] IX_RECSEL = 7'h0D;
    localparam logic [IDX_W-1:0] IX_PD     = 7'h13;
    localparam logic [IDX_W-1:0] IX_EXTID  = 7'h14;
    localparam logic [IDX_W-1:0] IX_EXT    = 7'h15;
    localparam logic [IDX_W-1:0] IX_DAC    = 7'h16;
    localparam logic [IDX_W-1:0] IX_ADC    = 7'h19;
    localparam logic [IDX_W-1:0] IX_MIC    = 7'h1A;
    localparam logic [IDX_W-1:0] IX_ID1    = 7'h3E;
    localparam logic [IDX_W-1:0] IX_ID2    = 7'h3F;

    // power-on value of one register word
    function automatic logic [REG_W-1:0] reset_value(input logic [IDX_W-1:0] ix);
        case (ix)
            7'h01, 7'h03, 7'h0F:                 return 16'h8000;
            7'h06, 7'h07:                        return 16'h8008;
            7'h08, 7'h09, 7'h0B, 7'h0C:          return 16'h8808;
            7'h13:                               return 16'h000F;
            7'h14:                               return 16'h0809;
            7'h15:                               return 16'h0009;
            7'h16, 7'h17, 7'h18, 7'h19, 7'h1A:   return RATE_48K;
            7'h3E:                               return 16'h8384;
            7'h3F:                               return 16'h7600;
            default:                             return '0;
        endcase
    endfunction

    // word index of volume channel ch
    function automatic logic [IDX_W-1:0] vol_index(input int ch);
        case (ch)
            0:       return IX_MASTER;
            1:       return IX_LINE;
            default: return IX_PCM;
        endcase
    endfunction
endpackage

// File: rtl/cmix_wr_filter.sv
// Write filter: turns a raw port write into a storage update.
// It applies the protection, nibble-keep, masking, rate gating and forcing rules.
// Assumes ext_q and pd_q are the current stored control and power-down words.
module cmix_wr_filter
    import cmix_pkg::*;
(
    input  logic              wr_en,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  ext_q,
    input  logic [REG_W-1:0]  pd_q,
    output logic              wr_go,
    output logic [IDX_W-1:0]  wr_ix,
    output logic [REG_W-1:0]  wr_val,
    output logic              force_ab,
    output logic              force_mic
);
    logic word_ok;

    // qualify: aligned word write inside the space
    always_comb word_ok = wr_en && (acc_size == ACC_WORD) && !addr[0]
                          && (addr < ADDR_W'(SPACE_BYTES));

    // per-register write rules
    always_comb begin
        wr_ix     = addr[IDX_W:1];
        wr_val    = wdata;
        wr_go     = word_ok;
        force_ab  = 1'b0;
        force_mic = 1'b0;
        if (word_ok) begin
            case (wr_ix)
                IX_ID1, IX_ID2, IX_EXTID: wr_go = 1'b0;
                IX_PD:     wr_val = {wdata[REG_W-1:PD_KEEP], pd_q[PD_KEEP-1:0]};
                IX_RECSEL: wr_val = {5'b0, wdata[8+SRC_W-1:8], 5'b0, wdata[SRC_W-1:0]};
                IX_DAC, IX_ADC: wr_go = ext_q[VRA_BIT];
                IX_MIC:    wr_go = ext_q[VRM_BIT];
                IX_EXT: begin
                    force_ab  = !wdata[VRA_BIT];
                    force_mic = !wdata[VRM_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmix_vol_decode.sv
// Volume decoder: splits each volume word into mute, left and right attenuation.
// Assumes words are packed channel 0 in the low bits.
module cmix_vol_decode
    import cmix_pkg::*;
(
    input  logic [NVOL*REG_W-1:0] vol_words,
    output logic [NVOL-1:0]       mute,
    output logic [NVOL*ATT_W-1:0] left_att,
    output logic [NVOL*ATT_W-1:0] right_att
);
    for (genvar c = 0; c < NVOL; c++) begin : g_ch
        // field extraction for channel c
        always_comb begin
            mute[c]                   = vol_words[c*REG_W + 15];
            left_att[c*ATT_W +: ATT_W]  = vol_words[c*REG_W + 8 +: ATT_W];
            right_att[c*ATT_W +: ATT_W] = vol_words[c*REG_W +: ATT_W];
        end
    end
endmodule

// File: rtl/cmix_rate_watch.sv
// Rate watcher: raises a one-cycle strobe when a rate word differs from its previous cycle value.
// Assumes the watched word resets to RATE_48K in the same cycle as this block.
module cmix_rate_watch
    import cmix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rate,
    output logic             chg
);
    logic [REG_W-1:0] prev_q;

    // remember last cycle's rate
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RATE_48K;
        else        prev_q <= rate;
    end

    // compare against it
    always_comb chg = (rate != prev_q);
endmodule

// File: rtl/codec_mixer_regs.sv
// Codec mixer register bank: word storage with defaults, a filtered write path,
// a registered read path, and decoded volume, record-source and rate outputs.
// Assumes one access per cycle and a synchronous active-low reset.
module codec_mixer_regs
    import cmix_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             acc_size,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    output logic                   rd_valid,
    output logic [REG_W-1:0]       rdata,
    output logic [NVOL-1:0]        vol_mute,
    output logic [NVOL*ATT_W-1:0]  vol_left,
    output logic [NVOL*ATT_W-1:0]  vol_right,
    output logic [SRC_W-1:0]       rec_left,
    output logic [SRC_W-1:0]       rec_right,
    output logic [REG_W-1:0]       dac_rate,
    output logic [REG_W-1:0]       adc_rate,
    output logic [REG_W-1:0]       mic_rate,
    output logic                   dac_rate_chg,
    output logic                   adc_rate_chg,
    output logic                   mic_rate_chg
);
    logic [REG_W-1:0]      regs [NREG];
    logic [REG_W-1:0]      ext_ctl_q;
    logic [REG_W-1:0]      pd_q;
    logic                  wr_go, force_ab, force_mic;
    logic [IDX_W-1:0]      wr_ix;
    logic [REG_W-1:0]      wr_val;
    logic                  rd_word, rd_in_range;
    logic [NVOL*REG_W-1:0] vol_words;
    logic [NRATE*REG_W-1:0] rate_words;
    logic [NRATE-1:0]      rate_chg;

    always_comb ext_ctl_q = regs[IX_EXT];
    always_comb pd_q      = regs[IX_PD];

    cmix_wr_filter u_filt (
        .wr_en(wr_en), .acc_size(acc_size), .addr(addr), .wdata(wdata),
        .ext_q(ext_ctl_q), .pd_q(pd_q), .wr_go(wr_go), .wr_ix(wr_ix),
        .wr_val(wr_val), .force_ab(force_ab), .force_mic(force_mic)
    );

    // storage: defaults on reset, filtered write, rate forcing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reset_value(IDX_W'(i));
        end else begin
            if (wr_go) regs[wr_ix] <= wr_val;
            if (force_ab) begin
                regs[IX_DAC] <= RATE_48K;
                regs[IX_ADC] <= RATE_48K;
            end
            if (force_mic) regs[IX_MIC] <= RATE_48K;
        end
    end

    // read qualification
    always_comb begin
        rd_word     = rd_en && (acc_size == ACC_WORD);
        rd_in_range = !addr[0] && (addr < ADDR_W'(SPACE_BYTES));
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_word;
            if (rd_word) rdata <= rd_in_range ? regs[addr[IDX_W:1]] : '1;
        end
    end

    // gather volume words
    for (genvar c = 0; c < NVOL; c++) begin : g_vol
        always_comb vol_words[c*REG_W +: REG_W] = regs[vol_index(c)];
    end

    cmix_vol_decode u_vol (
        .vol_words(vol_words), .mute(vol_mute),
        .left_att(vol_left), .right_att(vol_right)
    );

    // record source fields and rate words
    always_comb begin
        rec_right  = regs[IX_RECSEL][SRC_W-1:0];
        rec_left   = regs[IX_RECSEL][8 +: SRC_W];
        dac_rate   = regs[IX_DAC];
        adc_rate   = regs[IX_ADC];
        mic_rate   = regs[IX_MIC];
        rate_words = {mic_rate, adc_rate, dac_rate};
    end

    for (genvar r = 0; r < NRATE; r++) begin : g_rate
        cmix_rate_watch u_watch (
            .clk(clk), .rst_n(rst_n),
            .rate(rate_words[r*REG_W +: REG_W]), .chg(rate_chg[r])
        );
    end

    // strobe outputs
    always_comb begin
        dac_rate_chg = rate_chg[0];
        adc_rate_chg = rate_chg[1];
        mic_rate_chg = rate_chg[2];
    end
endmodule

// File: rtl/cmix_regs_chk.sv
// Checker for codec_mixer_regs: protocol and rate-rule properties, bound to the top.
module cmix_regs_chk
    import cmix_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        acc_size,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic              rd_valid,
    input logic [REG_W-1:0]  rdata,
    input logic [REG_W-1:0]  dac_rate,
    input logic [REG_W-1:0]  adc_rate,
    input logic [REG_W-1:0]  mic_rate,
    input logic              dac_rate_chg,
    input logic [REG_W-1:0]  ext_ctl_q
);
    logic armed;

    // arm once a full cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    odd_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_size == ACC_WORD && addr[0]) |=> (rd_valid && rdata == 16'hFFFF));

    // R3
    odd_size_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_size != ACC_WORD) |=> !rd_valid);

    // R6
    dac_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_size == ACC_WORD && addr == 9'h02C && !ext_ctl_q[VRA_BIT]
         && !(wr_en && addr == 9'h02A)) |=> $stable(dac_rate));

    // R7
    force_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_size == ACC_WORD && addr == 9'h02A && !wdata[VRA_BIT])
        |=> (dac_rate == RATE_48K && adc_rate == RATE_48K));

    // R7
    force_mic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_size == ACC_WORD && addr == 9'h02A && !wdata[VRM_BIT])
        |=> (mic_rate == RATE_48K));

    // R10
    strobe_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dac_rate_chg) |-> (dac_rate != $past(dac_rate)));

    // R10
    quiet_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !dac_rate_chg) |-> (dac_rate == $past(dac_rate)));
endmodule

bind codec_mixer_regs cmix_regs_chk u_chk (.*);

// File: tb/sim_codec_mixer_regs.sv
module sim_codec_mixer_regs;
    import cmix_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  acc_size = 2'd1;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        rd_valid;
    logic [15:0] rdata;
    logic [2:0]  vol_mute;
    logic [14:0] vol_left, vol_right;
    logic [2:0]  rec_left, rec_right;
    logic [15:0] dac_rate, adc_rate, mic_rate;
    logic        dac_rate_chg, adc_rate_chg, mic_rate_chg;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    codec_mixer_regs u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; acc_size = sz;
        @(negedge clk);
        wr_en = 1'b0; acc_size = 2'd1;
    endtask

    // driver: issue a word read and queue the expected word
    task automatic rd(input logic [8:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a; acc_size = 2'd1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare each read response with the queue head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected rd_valid", 32'd1, 32'd0);
            else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {16'h0, rdata}, {16'h0, e});
            end
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on outputs
        check("R1 dac_rate", {16'h0, dac_rate}, 32'hBB80);
        check("R1 mic_rate", {16'h0, mic_rate}, 32'hBB80);
        check("R1 rd_valid", {31'h0, rd_valid}, 0);
        check("R8 reset mute", {29'h0, vol_mute}, 32'h7);
        check("R8 reset line left", {27'h0, vol_left[9:5]}, 32'h8);
        check("R10 no strobe after reset", {29'h0, dac_rate_chg, adc_rate_chg, mic_rate_chg}, 0);
        rd(9'h006, 16'h8000, "R1 0x06");
        rd(9'h00C, 16'h8008, "R1 0x0C");
        rd(9'h012, 16'h8808, "R1 0x12");
        rd(9'h026, 16'h000F, "R1 0x26");
        rd(9'h028, 16'h0809, "R1 0x28");
        rd(9'h02A, 16'h0009, "R1 0x2A");
        rd(9'h030, 16'hBB80, "R1 0x30");
        rd(9'h07C, 16'h8384, "R1 0x7C");
        rd(9'h040, 16'h0000, "R1 0x40");
        // R2 odd and out of range
        rd(9'h003, 16'hFFFF, "R2 odd");
        rd(9'h0FF, 16'hFFFF, "R2 0xFF");
        rd(9'h100, 16'hFFFF, "R2 0x100");
        rd(9'h0FE, 16'h0000, "R2 last word");
        // R3 byte/dword
        wr(9'h02E, 16'h1111, 2'd0);
        wr(9'h02E, 16'h2222, 2'd2);
        rd(9'h02E, 16'hBB80, "R3 size writes dropped");
        @(negedge clk);
        rd_en = 1'b1; addr = 9'h02E; acc_size = 2'd2;
        @(negedge clk);
        rd_en = 1'b0; acc_size = 2'd1;
        check("R3 dword read no valid", {31'h0, rd_valid}, 0);
        // R4 protected
        wr(9'h07C, 16'h0000); wr(9'h07E, 16'h1234); wr(9'h028, 16'hFFFF);
        rd(9'h07C, 16'h8384, "R4 0x7C");
        rd(9'h07E, 16'h7600, "R4 0x7E");
        rd(9'h028, 16'h0809, "R4 0x28");
        // R5 power-down nibble
        wr(9'h026, 16'hFFF0);
        rd(9'h026, 16'hFFFF, "R5 ones");
        wr(9'h026, 16'h0000);
        rd(9'h026, 16'h000F, "R5 zeros");
        // R11 plain store
        wr(9'h02E, 16'h7D00);
        rd(9'h02E, 16'h7D00, "R11 0x2E");
        // R6/R10 enabled rate write with strobe
        wr(9'h02C, 16'hAC44);
        check("R10 dac strobe", {31'h0, dac_rate_chg}, 1);
        check("R6 dac accepted", {16'h0, dac_rate}, 32'hAC44);
        @(negedge clk);
        check("R10 strobe one cycle", {31'h0, dac_rate_chg}, 0);
        wr(9'h02C, 16'hAC44);
        check("R10 same value no strobe", {31'h0, dac_rate_chg}, 0);
        wr(9'h032, 16'h5622);
        check("R6 adc accepted", {16'h0, adc_rate}, 32'h5622);
        // R7 VRA clear, VRM set
        wr(9'h02A, 16'h0008);
        check("R7 dac forced", {16'h0, dac_rate}, 32'hBB80);
        check("R7 adc forced", {16'h0, adc_rate}, 32'hBB80);
        check("R10 dac strobe on force", {31'h0, dac_rate_chg}, 1);
        wr(9'h02C, 16'h5622);
        check("R6 dac gated", {16'h0, dac_rate}, 32'hBB80);
        wr(9'h034, 16'h3E80);
        check("R6 mic accepted", {16'h0, mic_rate}, 32'h3E80);
        check("R10 mic strobe", {31'h0, mic_rate_chg}, 1);
        wr(9'h02A, 16'h0000);
        check("R7 mic forced", {16'h0, mic_rate}, 32'hBB80);
        wr(9'h034, 16'h1234);
        check("R6 mic gated", {16'h0, mic_rate}, 32'hBB80);
        rd(9'h02A, 16'h0000, "R7 ctl stored");
        // R8 volume decode
        wr(9'h002, 16'h9F03);
        wr(9'h018, 16'h0A15);
        check("R8 mute", {29'h0, vol_mute}, 32'h3);
        check("R8 master left", {27'h0, vol_left[4:0]}, 32'h1F);
        check("R8 master right", {27'h0, vol_right[4:0]}, 32'h03);
        check("R8 pcm left", {27'h0, vol_left[14:10]}, 32'h0A);
        check("R8 pcm right", {27'h0, vol_right[14:10]}, 32'h15);
        // R9 record select
        wr(9'h01A, 16'hFFFF);
        rd(9'h01A, 16'h0707, "R9 masked");
        wr(9'h01A, 16'h0502);
        check("R9 rec", {26'h0, rec_left, rec_right}, {26'h0, 3'd5, 3'd2});
        // R1 reset reload mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(9'h026, 16'h000F, "R1 reload 0x26");
        rd(9'h02E, 16'hBB80, "R1 reload 0x2E");
        rd(9'h002, 16'h8000, "R1 reload 0x02");
        repeat (3) @(negedge clk);
        check("R2 all reads answered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule